// File: doc/BRIEF.md
# Configurable Logic-Array Output Cell

This block is one output cell of a sum-of-products programmable logic array. It takes the OR-sum of its product terms and its own output-enable term. It also takes two asynchronous control terms that every cell shares: one sets the cell, one clears it. A clock, a test load port and two static mode bits complete the inputs. From these it produces a tri-state pin, modelled as a value plus a drive enable, and a feedback line back into the array.

One mode bit picks how the pin is driven. In registered mode the pin comes from an edge-triggered flip-flop, so the array can build state machines. In combinational mode the pin comes straight from the OR-sum. The other mode bit inverts the pin level in either mode. In registered mode the feedback is the flip-flop's true output. In combinational mode the feedback is the level on the pin, so a cell whose enable term is held low works as an extra input. A cell that switches its enable term works as a bidirectional I/O.

The shared set and clear terms act on the flip-flop before the polarity inversion. An active-low cell therefore shows a low pin when the set term fires. The test load port forces any chosen state into the flip-flop at a clock edge, whatever the array produces. A synchronous reset clears the state at start-up.

Top module: `pal_macrocell`

## Requirements
- R1: With `cfg_reg`=0, `pin_out` equals `sum_in` when `cfg_act_low`=0 and its inverse when `cfg_act_low`=1, in the same cycle and with no clock edge needed.
- R2: With `cfg_reg`=1, the state takes `sum_in` on each rising clock edge. `pin_out` then shows the state, inverted when `cfg_act_low`=1, and does not change between edges.
- R3: With `cfg_reg`=1, `fb_out` equals the true state whatever the value of `cfg_act_low`.
- R4: With `cfg_reg`=0, `fb_out` equals `pin_in`, the level on the pin, including a level driven from outside while the cell is not driving.
- R5: `pin_oe` is 1 exactly when `oe_term` is 1. With `oe_term` held low the cell only listens to the pin.
- R6: A high `arst_term` clears the state at once, without a clock edge. An active-low registered cell then shows a high pin.
- R7: A high `apre_term` sets the state at once, without a clock edge. An active-low registered cell then shows a low pin.
- R8: When `arst_term` and `apre_term` are high together, the clear wins and the state stays 0 across clock edges.
- R9: With `pload_en`=1 at a rising edge, and no asynchronous term active, the state takes `pload_val` and `sum_in` is ignored.
- R10: With `rst`=1 at a rising edge and no asynchronous term active, the state becomes 0. This takes priority over `pload_en`.
- R11: In combinational mode the asynchronous set and clear terms have no effect on `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state register |
| rst | input | 1 | Synchronous active-high clear of the state |
| cfg_reg | input | 1 | Mode: 1 = registered, 0 = combinational |
| cfg_act_low | input | 1 | Polarity: 1 = pin inverted (active-low) |
| sum_in | input | 1 | OR-sum of this cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| apre_term | input | 1 | Shared asynchronous set term |
| arst_term | input | 1 | Shared asynchronous clear term |
| pload_en | input | 1 | Test load strobe, sampled at the clock edge |
| pload_val | input | 1 | Value written by the test load |
| pin_in | input | 1 | Resolved level seen on the pin |
| pin_out | output | 1 | Value the cell drives onto the pin |
| pin_oe | output | 1 | Pin drive enable |
| fb_out | output | 1 | Feedback line into the array |

## Verification
The polarity mux is driven with all four pairs of sum and polarity in both modes. This separates a missing inversion from an inversion placed in the wrong mode. In registered mode the pin is sampled both before and after an edge, and feedback is read with each polarity. This shows that feedback takes the true state rather than the pin level. In combinational mode, when the cell stops driving, the bench drives the pin from outside with both levels to prove that feedback follows the pin. The priority order is tested with conflicting pairs: set against clear, synchronous reset against load, and load against the OR-sum. Each pair gives a different state depending on which input wins.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  localparam logic MODE_COMB = 1'b0;
  localparam logic MODE_REG  = 1'b1;
  localparam logic CLEAR_VAL = 1'b0;
  localparam logic SET_VAL   = 1'b1;
endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import pal_mc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arst,
  input  logic apre,
  input  logic ld_en,
  input  logic ld_val,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge arst or posedge apre) begin
    if (arst)       q <= CLEAR_VAL;
    else if (apre)  q <= SET_VAL;
    else if (rst)   q <= CLEAR_VAL;
    else if (ld_en) q <= ld_val;
    else            q <= d;
  end

  p_areset_r6: assert property (@(posedge clk) disable iff (rst)
    arst |-> (q == CLEAR_VAL));
  p_apreset_r7: assert property (@(posedge clk) disable iff (rst)
    (apre && !arst) |-> (q == SET_VAL));
  p_preload_r9: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !apre && !arst) |=> (arst || apre || q == $past(ld_val)));
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !apre && !arst) |=> (arst || apre || q == $past(d)));
  p_sync_clear_r10: assert property (@(posedge clk) disable iff (arst)
    (rst && !apre) |=> (apre || q == CLEAR_VAL));
endmodule

// File: rtl/mc_out_sel.sv
module mc_out_sel
  import pal_mc_pkg::*;
(
  input  logic mode,
  input  logic act_low,
  input  logic sum,
  input  logic q,
  output logic lvl
);
  logic pre_pol;
  always_comb begin
    pre_pol = (mode == MODE_REG) ? q : sum;
    lvl     = pre_pol ^ act_low;
  end
endmodule

// File: rtl/mc_fb_sel.sv
module mc_fb_sel
  import pal_mc_pkg::*;
(
  input  logic mode,
  input  logic q,
  input  logic pin_lvl,
  output logic fb
);
  always_comb fb = (mode == MODE_REG) ? q : pin_lvl;
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_mc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_reg,
  input  logic cfg_act_low,
  input  logic sum_in,
  input  logic oe_term,
  input  logic apre_term,
  input  logic arst_term,
  input  logic pload_en,
  input  logic pload_val,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_out
);
  logic state_q;

  mc_state_reg u_reg (
    .clk(clk), .rst(rst), .arst(arst_term), .apre(apre_term),
    .ld_en(pload_en), .ld_val(pload_val), .d(sum_in), .q(state_q)
  );

  mc_out_sel u_out (
    .mode(cfg_reg), .act_low(cfg_act_low), .sum(sum_in),
    .q(state_q), .lvl(pin_out)
  );

  mc_fb_sel u_fb (
    .mode(cfg_reg), .q(state_q), .pin_lvl(pin_in), .fb(fb_out)
  );

  assign pin_oe = oe_term;

  p_fb_path_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_reg == MODE_REG) |-> ((pin_out ^ cfg_act_low) == fb_out));
endmodule

// File: tb/test_pal_macrocell.sv
module test_pal_macrocell;
  logic clk = 1'b0;
  logic rst, cfg_reg, cfg_act_low, sum_in, oe_term;
  logic apre_term, arst_term, pload_en, pload_val, ext_lvl;
  logic pin_in, pin_out, pin_oe, fb_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign pin_in = pin_oe ? pin_out : ext_lvl;

  pal_macrocell i_pal_macrocell (
    .clk(clk), .rst(rst), .cfg_reg(cfg_reg), .cfg_act_low(cfg_act_low),
    .sum_in(sum_in), .oe_term(oe_term), .apre_term(apre_term),
    .arst_term(arst_term), .pload_en(pload_en), .pload_val(pload_val),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic edge_settle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1; cfg_reg = 1; cfg_act_low = 0; sum_in = 1; oe_term = 1;
    apre_term = 0; arst_term = 0; pload_en = 1; pload_val = 1; ext_lvl = 0;
    edge_settle(); edge_settle();
    chk("R10 reset clears state over load", fb_out, 1'b0);
    chk("R10 reset pin level", pin_out, 1'b0);
    @(negedge clk); rst = 0; pload_en = 0; sum_in = 0;
  endtask

  task automatic t_comb();
    cfg_reg = 0; oe_term = 1;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++) begin
        @(negedge clk); cfg_act_low = p[0]; sum_in = s[0]; #1;
        chk("R1 comb polarity", pin_out, s[0] ^ p[0]);
        chk("R4 comb feedback from driven pin", fb_out, s[0] ^ p[0]);
      end
  endtask

  task automatic t_oe_input();
    cfg_reg = 0; cfg_act_low = 0; sum_in = 1;
    @(negedge clk); oe_term = 0; ext_lvl = 0; #1;
    chk("R5 pin released", pin_oe, 1'b0);
    chk("R4 input use low", fb_out, 1'b0);
    ext_lvl = 1; #1;
    chk("R4 input use high", fb_out, 1'b1);
    oe_term = 1; #1;
    chk("R5 pin driven", pin_oe, 1'b1);
  endtask

  task automatic t_registered();
    cfg_reg = 1; cfg_act_low = 0;
    @(negedge clk); sum_in = 0; edge_settle();
    @(negedge clk); sum_in = 1; #1;
    chk("R2 pin holds between edges", pin_out, 1'b0);
    edge_settle();
    chk("R2 captured high", pin_out, 1'b1);
    chk("R3 feedback true state", fb_out, 1'b1);
    @(negedge clk); cfg_act_low = 1; #1;
    chk("R2 active-low pin", pin_out, 1'b0);
    chk("R3 feedback ignores polarity", fb_out, 1'b1);
    @(negedge clk); sum_in = 0; edge_settle();
    chk("R2 captured low active-low", pin_out, 1'b1);
    chk("R3 feedback low", fb_out, 1'b0);
  endtask

  task automatic t_preload();
    cfg_reg = 1; cfg_act_low = 0;
    @(negedge clk); sum_in = 0; pload_en = 1; pload_val = 1; edge_settle();
    chk("R9 load overrides sum", fb_out, 1'b1);
    @(negedge clk); sum_in = 1; pload_val = 0; edge_settle();
    chk("R9 load zero overrides sum", fb_out, 1'b0);
    @(negedge clk); pload_en = 0; edge_settle();
    chk("R2 capture resumes after load", fb_out, 1'b1);
    @(negedge clk); rst = 1; pload_en = 1; pload_val = 1; edge_settle();
    chk("R10 reset beats load", fb_out, 1'b0);
    @(negedge clk); rst = 0; pload_en = 0; sum_in = 0;
  endtask

  task automatic t_async();
    cfg_reg = 1; cfg_act_low = 1; sum_in = 0;
    @(negedge clk); apre_term = 1; #1;
    chk("R7 set without clock", fb_out, 1'b1);
    chk("R7 active-low pin low on set", pin_out, 1'b0);
    @(negedge clk); apre_term = 0; arst_term = 1; #1;
    chk("R6 clear without clock", fb_out, 1'b0);
    chk("R6 active-low pin high on clear", pin_out, 1'b1);
    @(negedge clk); apre_term = 1; #1;
    chk("R8 clear wins", fb_out, 1'b0);
    edge_settle();
    chk("R8 clear wins across edge", fb_out, 1'b0);
    @(negedge clk); apre_term = 0; arst_term = 0;
  endtask

  task automatic t_comb_async();
    cfg_reg = 0; cfg_act_low = 0; oe_term = 1;
    @(negedge clk); sum_in = 1; apre_term = 1; #1;
    chk("R11 set no effect in comb", pin_out, 1'b1);
    sum_in = 0; #1;
    chk("R11 set no effect in comb low", pin_out, 1'b0);
    @(negedge clk); apre_term = 0; arst_term = 1; sum_in = 1; #1;
    chk("R11 clear no effect in comb", pin_out, 1'b1);
    @(negedge clk); arst_term = 0;
  endtask

  initial begin
    t_reset();
    t_comb();
    t_oe_input();
    t_registered();
    t_preload();
    t_async();
    t_comb_async();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule